// File: doc/BRIEF.md
# UART Transmit Queue Status Control

This block governs a sixteen-character transmit queue that sits between a host and a UART serializer. The host pushes characters into the queue. The block offers the oldest character to the serializer through a load request, and the serializer takes it with a one-cycle acknowledge. The serializer later reports the end of the final stop bit with a one-cycle strobe. From these events the block derives two status flags for the host. The ready flag means the queue is drained and can be refilled. The empty flag means the line has underrun, with both the queue and the shift register vacant.

The transmitter is switched on and off with two single-cycle command strobes. While it is off, the queue is held flushed, host writes are thrown away and both flags stay low. Switching it on raises the ready flag. The empty flag only appears after a real underrun. The serial bit engine lies outside this block.

Top module: `uart_txq_ctrl`

## Requirements
- R1: After reset the transmitter is off, and `tx_ready`, `tx_empty` and `load_req` are all 0.
- R2: An `enable_cmd` pulse while off and with `disable_cmd` low turns the transmitter on, and `tx_ready` reads 1 from the next cycle.
- R3: A host write accepted while on clears both `tx_ready` and `tx_empty` in the next cycle.
- R4: Writes made while the transmitter is off are discarded. After a later enable, `load_req` stays 0 and `tx_ready` stays 1.
- R5: The queue holds 16 characters. A write to a full queue is ignored, and exactly the first 16 characters reach the serializer.
- R6: `load_req` is 1 exactly when the transmitter is on, the queue is not empty and the shift register is idle. `head_data` shows the oldest queued character, so characters leave in write order.
- R7: When an acknowledged load takes the last queued character and no write occurs in that cycle, `tx_ready` reads 1 in the next cycle. It stays 0 while characters remain.
- R8: A `stop_done` strobe while on with an empty queue sets `tx_empty` in the next cycle. With characters still queued, `tx_empty` stays 0.
- R9: A `disable_cmd` pulse flushes the queue and clears `tx_ready` and `tx_empty` in the next cycle. Characters queued before it are never offered after a re-enable.
- R10: When `enable_cmd` and `disable_cmd` arrive together, disable wins and the transmitter stays off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Character from the host |
| enable_cmd | input | 1 | Transmitter-on command strobe |
| disable_cmd | input | 1 | Transmitter-off command strobe |
| load_ack | input | 1 | Serializer took `head_data` into the shift register |
| stop_done | input | 1 | Serializer finished the final stop bit |
| head_data | output | 8 | Oldest queued character |
| load_req | output | 1 | A character is available for an idle shift register |
| tx_ready | output | 1 | Queue drained and ready for the host |
| tx_empty | output | 1 | Queue and shift register both vacant |

## Verification
A pointer or count that drifts shows up within one load at the ports. `head_data` then differs from the written order, or `load_req` rises or falls on the wrong number of characters. Because the flags are registered, a wrong set or clear is visible one cycle after the event that caused it. A flush that fails to happen shows up as a stale load request as soon as the transmitter is switched back on. The bench sweeps write bursts from 0 to 17 characters and drains each burst through a timed serializer model, so that every queue fill level meets the flags.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic {
    SHIFT_IDLE = 1'b0,
    SHIFT_BUSY = 1'b1
  } shift_state_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = bump(wptr_q);
      if (pop)  rptr_d = bump(rptr_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && !flush && (wptr_q == AW'(g))) slot_q[g] <= din;
      end
    end
  endgenerate

  assign dout  = slot_q[rptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          turn_on,
  input  logic          turn_off,
  input  logic          on_q,
  input  logic          wr_acc,
  input  logic          pop,
  input  logic [CW-1:0] count,
  input  logic          stop_done,
  output logic          tx_ready,
  output logic          tx_empty
);
  logic rdy_q, rdy_d, emt_q, emt_d;
  logic last_out;

  assign last_out = pop && (count == CW'(1));

  always_comb begin
    rdy_d = rdy_q;
    emt_d = emt_q;
    if (turn_off || wr_acc) begin
      rdy_d = 1'b0;
      emt_d = 1'b0;
    end else begin
      if (turn_on || last_out) rdy_d = 1'b1;
      if (stop_done && on_q && (count == '0)) emt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      emt_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      emt_q <= emt_d;
    end
  end

  assign tx_ready = rdy_q;
  assign tx_empty = emt_q;

  // R3
  wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !tx_ready && !tx_empty);
  // R9
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_off |=> !tx_ready && !tx_empty);
endmodule

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          enable_cmd,
  input  logic          disable_cmd,
  input  logic          load_ack,
  input  logic          stop_done,
  output logic [DW-1:0] head_data,
  output logic          load_req,
  output logic          tx_ready,
  output logic          tx_empty
);
  import txq_pkg::*;

  logic          on_q, on_d;
  shift_state_t  sh_q, sh_d;
  logic          wr_acc, pop, turn_on;
  logic [CW-1:0] count;
  logic          full, empty;

  assign turn_on = enable_cmd && !disable_cmd && !on_q;
  assign wr_acc  = wr_en && on_q && !full && !disable_cmd;
  assign pop     = load_ack && load_req;

  always_comb begin
    on_d = on_q;
    if (disable_cmd)     on_d = 1'b0;
    else if (enable_cmd) on_d = 1'b1;
    sh_d = sh_q;
    case (sh_q)
      SHIFT_IDLE: if (pop)       sh_d = SHIFT_BUSY;
      SHIFT_BUSY: if (stop_done) sh_d = SHIFT_IDLE;
      default:                   sh_d = SHIFT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0;
      sh_q <= SHIFT_IDLE;
    end else begin
      on_q <= on_d;
      sh_q <= sh_d;
    end
  end

  txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_acc),
    .pop   (pop),
    .flush (disable_cmd),
    .din   (wr_data),
    .dout  (head_data),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  txq_flags #(.CW(CW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .turn_on   (turn_on),
    .turn_off  (disable_cmd),
    .on_q      (on_q),
    .wr_acc    (wr_acc),
    .pop       (pop),
    .count     (count),
    .stop_done (stop_done),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty)
  );

  assign load_req = on_q && !empty && (sh_q == SHIFT_IDLE);

  // R4
  off_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |-> empty);
  // R7
  ready_tracks_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready == (on_q && empty));
  // R6
  load_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !load_req);
  // R10
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_cmd && disable_cmd) |=> !on_q);
endmodule

// File: tb/sim_uart_txq_ctrl.sv
module sim_uart_txq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, enable_cmd, disable_cmd, load_ack, stop_done;
  logic [7:0] wr_data;
  logic [7:0] head_data;
  logic       load_req, tx_ready, tx_empty;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] expq [$];

  always #10 clk = ~clk;

  uart_txq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .enable_cmd(enable_cmd), .disable_cmd(disable_cmd),
    .load_ack(load_ack), .stop_done(stop_done), .head_data(head_data),
    .load_req(load_req), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_on();
    enable_cmd = 1'b1; tick(); enable_cmd = 1'b0;
  endtask

  task automatic pulse_off();
    disable_cmd = 1'b1; tick(); disable_cmd = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  // serializer model: takes each offered character, stays busy, then ends it
  task automatic drain(input int expect_n);
    int sent = 0;
    while (load_req) begin
      chk("R6 head order", head_data, (expq.size() > 0) ? expq[0] : -1);
      if (expq.size() > 0) void'(expq.pop_front());
      load_ack = 1'b1; tick(); load_ack = 1'b0;
      sent++;
      chk("R7 ready after load", tx_ready, (sent == expect_n) ? 1 : 0);
      for (int k = 0; k < 3; k++) begin
        chk("R6 no request while busy", load_req, 0);
        tick();
      end
      stop_done = 1'b1; tick(); stop_done = 1'b0;
      chk("R8 empty after stop", tx_empty, (sent == expect_n) ? 1 : 0);
    end
    chk("R5 characters sent", sent, expect_n);
  endtask

  initial begin
    #3000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; enable_cmd = 1'b0;
    disable_cmd = 1'b0; load_ack = 1'b0; stop_done = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1
    chk("R1 ready at reset", tx_ready, 0);
    chk("R1 empty at reset", tx_empty, 0);
    chk("R1 request at reset", load_req, 0);

    // R4: writes while off are discarded
    for (int i = 0; i < 3; i++) host_write(8'hA0 + 8'(i));
    chk("R4 ready while off", tx_ready, 0);
    pulse_on();
    // R2
    chk("R2 ready after enable", tx_ready, 1);
    chk("R4 nothing offered", load_req, 0);
    chk("R4 ready kept", tx_ready, 1);
    chk("R2 empty not set by enable", tx_empty, 0);

    // sweep burst sizes: R3 R5 R6 R7 R8
    for (int n = 0; n <= 17; n++) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] v;
        v = 8'((n * 29 + i * 13 + 5) & 255);
        host_write(v);
        if (i < 16) expq.push_back(v);
        if (i == 0) begin
          chk("R3 ready cleared", tx_ready, 0);
          chk("R3 empty cleared", tx_empty, 0);
        end
      end
      if (n > 0) chk("R6 request raised", load_req, 1);
      drain((n > 16) ? 16 : n);
      chk("R5 queue model drained", expq.size(), 0);
      expq.delete();
    end

    // R8: stop with characters still queued keeps empty low
    host_write(8'h11); host_write(8'h22);
    load_ack = 1'b1; tick(); load_ack = 1'b0;
    tick();
    stop_done = 1'b1; tick(); stop_done = 1'b0;
    chk("R8 empty held low", tx_empty, 0);
    chk("R6 next head", head_data, 8'h22);
    chk("R7 ready held low", tx_ready, 0);

    // R9: disable flushes and clears flags
    host_write(8'h33);
    pulse_off();
    chk("R9 ready cleared", tx_ready, 0);
    chk("R9 empty cleared", tx_empty, 0);
    chk("R9 no request", load_req, 0);
    pulse_on();
    chk("R9 flushed after re-enable", load_req, 0);
    chk("R9 ready after re-enable", tx_ready, 1);

    // R10: enable and disable together
    pulse_off();
    enable_cmd = 1'b1; disable_cmd = 1'b1; tick();
    enable_cmd = 1'b0; disable_cmd = 1'b0;
    chk("R10 stays off", tx_ready, 0);
    host_write(8'h44);
    chk("R10 write discarded", load_req, 0);
    pulse_on();
    chk("R10 later enable", tx_ready, 1);
    chk("R10 no stale char", load_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule